// File: doc/BRIEF.md
# Latch-Framed Serial Command Port

This block is a write-only slave for a three-wire control link. A host drives a serial clock, a data line and an active-low latch line. While the latch is low, the block shifts in one bit from the data line on each rising edge of the serial clock. When the latch rises, the block checks that exactly sixteen bits arrived. If so, it hands the word over to the system clock domain, where it lands in a small bank of control registers. The link has no data output.

The serial clock may run freely or only during frames. It bears no phase or frequency relation to the system clock. For this reason, a completed word is announced by flipping a single toggle flag, and the word itself stays still. The toggle passes through a multi-flop synchronizer, and its edge writes the held word into the register bank. The upper six bits of a word give the register address and the lower ten bits give the value. Register 0 controls the audio converter: it holds a serial audio format field and a sample word width field.

Top module: `sctl_port`

## Requirements
- R1: After reset, every register reads zero. As a result, `fmt_sel` is 2'b00 (I2S) and `width_sel` is 2'b00 (24-bit).
- R2: Bits are taken most significant first on rising serial clock edges while `frame_n` is low. In the 16-bit word, bits 15:10 are the register address and bits 9:0 are the value.
- R3: A frame changes a register only if exactly 16 rising serial clock edges occurred while `frame_n` was low. A frame with 15 or 17 edges changes no register.
- R4: Rising serial clock edges while `frame_n` is high change no register and do not disturb the bit count of the next frame.
- R5: A valid word whose address is `NUM_REGS` or greater changes no register.
- R6: `fmt_sel` equals register 0 bits 5:4 (00 I2S, 01 right-justified, 10 DSP, 11 left-justified). `width_sel` equals register 0 bits 9:8 (00 24-bit, 01 20-bit, 10 18-bit, 11 16-bit).
- R7: A valid word is written to its register within 8 system clock cycles after `frame_n` rises. Registers change on no other system clock cycle.
- R8: Writing one register leaves all other registers unchanged. A later write to the same address replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data, sampled on rising `sclk` |
| frame_n | input | 1 | Active-low frame latch |
| reg_flat | output | NUM_REGS*DATA_W | All registers, register 0 in the low bits |
| fmt_sel | output | 2 | Serial audio format select |
| width_sel | output | 2 | Sample word width select |

## Verification
The bench sends frames that are one bit short and one bit long. A design that counted loosely would write a shifted word into a register. It also pulses the serial clock while the latch is high, both between frames and in the middle of a run. A design that let those edges through would load wrong data or reject the next good frame. Words are also sent to addresses just past the bank and to every address inside it. A design that decoded the address wrongly would overwrite a neighbouring register or drop a valid write. One directed word can only be decoded correctly if bits arrive most significant first. A design that shifted the wrong way would send that word to an unknown address, and the target register would stay at zero.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   localparam int unsigned WORD_BITS = 16;
   localparam int unsigned ADDR_BITS = 6;
   localparam int unsigned VAL_BITS  = 10;

   typedef enum logic [1:0] {
      FMT_I2S = 2'b00,
      FMT_RJ  = 2'b01,
      FMT_DSP = 2'b10,
      FMT_LJ  = 2'b11
   } audio_fmt_e;

   typedef enum logic [1:0] {
      WID_24 = 2'b00,
      WID_20 = 2'b01,
      WID_18 = 2'b10,
      WID_16 = 2'b11
   } word_wid_e;
endpackage

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              frame_n,
   output logic [WORD_W-1:0] held_word,
   output logic              wr_tgl
);
   localparam int unsigned CNT_MAX = WORD_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  cnt;
   logic              seen_gen;
   logic              frame_gen;

   // serial domain: shift while latch low, restart count on a new frame
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         sreg     <= '0;
         cnt      <= '0;
         seen_gen <= 1'b0;
      end else if (!frame_n) begin
         if (seen_gen != frame_gen) begin
            sreg     <= {{(WORD_W-1){1'b0}}, sdi};
            cnt      <= CNT_W'(1);
            seen_gen <= frame_gen;
         end else begin
            sreg <= {sreg[WORD_W-2:0], sdi};
            if (cnt != CNT_W'(CNT_MAX))
               cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // latch domain: close the frame, publish only exact-length words
   always_ff @(posedge frame_n or negedge rst_n) begin
      if (!rst_n) begin
         frame_gen <= 1'b0;
         wr_tgl    <= 1'b0;
         held_word <= '0;
      end else begin
         frame_gen <= ~seen_gen;
         if (cnt == CNT_W'(WORD_W) && seen_gen == frame_gen) begin
            held_word <= sreg;
            wr_tgl    <= ~wr_tgl;
         end
      end
   end
endmodule

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= tgl_in;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], tgl_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];

   assign pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NUM_REGS*DATA_W-1:0] reg_flat
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                                  r <= '0;
            else if (wr_en && wr_addr == ADDR_W'(gi))    r <= wr_data;
         assign reg_flat[gi*DATA_W +: DATA_W] = r;
      end
   endgenerate
endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
   parameter int unsigned WORD_W      = sctl_pkg::WORD_BITS,
   parameter int unsigned ADDR_W      = sctl_pkg::ADDR_BITS,
   parameter int unsigned DATA_W      = sctl_pkg::VAL_BITS,
   parameter int unsigned NUM_REGS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sclk,
   input  logic                       sdi,
   input  logic                       frame_n,
   output logic [NUM_REGS*DATA_W-1:0] reg_flat,
   output logic [1:0]                 fmt_sel,
   output logic [1:0]                 width_sel
);
   generate
      if (WORD_W != ADDR_W + DATA_W) begin : g_bad_split
         $error("word width must equal address plus data width");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("register count does not fit the address field");
      end
      if (DATA_W < 10) begin : g_bad_data
         $error("data width too small for the converter control fields");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs at least two stages");
      end
   endgenerate

   logic [WORD_W-1:0] held_word;
   logic              wr_tgl;
   logic              wr_pulse;

   sctl_shift #(.WORD_W(WORD_W)) i_shift (
      .rst_n     (rst_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .frame_n   (frame_n),
      .held_word (held_word),
      .wr_tgl    (wr_tgl)
   );

   sctl_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tgl_in (wr_tgl),
      .pulse  (wr_pulse)
   );

   sctl_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_pulse),
      .wr_addr  (held_word[WORD_W-1 -: ADDR_W]),
      .wr_data  (held_word[DATA_W-1:0]),
      .reg_flat (reg_flat)
   );

   assign fmt_sel   = reg_flat[5:4];
   assign width_sel = reg_flat[9:8];
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 10,
   parameter int unsigned NUM_REGS = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_pulse,
   input logic [WORD_W-1:0]          held_word,
   input logic [NUM_REGS*DATA_W-1:0] reg_flat,
   input logic [1:0]                 fmt_sel,
   input logic [1:0]                 width_sel
);
   logic [ADDR_W-1:0] a;
   assign a = held_word[WORD_W-1 -: ADDR_W];

   AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pulse |=> $stable(reg_flat)); // R7
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse); // R7
   AST_UNKNOWN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && a >= ADDR_W'(NUM_REGS)) |=> $stable(reg_flat)); // R5
   AST_FMT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && a == '0) |=> fmt_sel == $past(held_word[5:4])); // R6
   AST_WIDTH_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && a == '0) |=> width_sel == $past(held_word[9:8])); // R6
endmodule

bind sctl_port sctl_port_chk #(
   .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_pulse  (wr_pulse),
   .held_word (held_word),
   .reg_flat  (reg_flat),
   .fmt_sel   (fmt_sel),
   .width_sel (width_sel)
);

// File: tb/test_sctl_port.sv
`timescale 1ns/1ps
module test_sctl_port;
   localparam int NREG = 4;
   localparam int DW   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic frame_n = 1'b1;
   logic [NREG*DW-1:0] reg_flat;
   logic [1:0] fmt_sel, width_sel;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] model [NREG];

   sctl_port i_sctl_port (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .frame_n(frame_n),
      .reg_flat(reg_flat), .fmt_sel(fmt_sel), .width_sel(width_sel)
   );

   always #2.5 clk = ~clk;

   function automatic logic [NREG*DW-1:0] model_flat();
      logic [NREG*DW-1:0] f;
      for (int i = 0; i < NREG; i++) f[i*DW +: DW] = model[i];
      return f;
   endfunction

   task automatic check_all(input string req);
      total++;
      if (reg_flat !== model_flat()) begin
         bad++;
         $display("FAIL %s regs actual=%h expected=%h", req, reg_flat, model_flat());
      end
      total++;
      if (fmt_sel !== model[0][5:4] || width_sel !== model[0][9:8]) begin
         bad++;
         $display("FAIL %s/R6 fmt,width actual=%b,%b expected=%b,%b", req,
                  fmt_sel, width_sel, model[0][5:4], model[0][9:8]);
      end
   endtask

   // nbits edges inside the frame; bits beyond 16 are taken as zeros
   task automatic send_frame(input logic [15:0] w, input int nbits);
      frame_n = 1'b0;
      #15;
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 16) ? w[15-i] : 1'b0;
         #20 sclk = 1'b1;
         #20 sclk = 1'b0;
      end
      #15 frame_n = 1'b1;
      if (nbits == 16 && w[15:10] < NREG) model[w[15:10]] = w[9:0];
      repeat (10) @(posedge clk);
      #1;
   endtask

   task automatic stray_edges(input int n);
      for (int i = 0; i < n; i++) begin
         sdi = 1'($urandom);
         #20 sclk = 1'b1;
         #20 sclk = 1'b0;
      end
      repeat (10) @(posedge clk);
      #1;
   endtask

   initial begin
      #900000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5C71_0A3B));
      for (int i = 0; i < NREG; i++) model[i] = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 reset");

      // R2: most significant bit first gives address 1, value 3
      send_frame(16'h0403, 16);
      check_all("R2 msb-first");
      // R6: format right-justified, width 16-bit
      send_frame({6'd0, 2'b11, 2'b00, 2'b01, 4'h0}, 16);
      check_all("R6 fields");
      // R3: short and long frames
      send_frame({6'd2, 10'h3FF}, 15);
      check_all("R3 short");
      send_frame({6'd2, 10'h155}, 17);
      check_all("R3 long");
      // R4: stray edges with latch high, then a good frame
      stray_edges(5);
      check_all("R4 stray");
      send_frame({6'd3, 10'h2A5}, 16);
      check_all("R4 after-stray");
      // R5: first unknown address
      send_frame({6'(NREG), 10'h3FF}, 16);
      check_all("R5 unknown");
      // R8: overwrite and neighbours untouched
      send_frame({6'd3, 10'h0F0}, 16);
      check_all("R8 overwrite");
      // R7: empty frame publishes nothing
      send_frame(16'h0000, 0);
      check_all("R7 empty");

      for (int k = 0; k < 150; k++) begin
         logic [15:0] w;
         int sel, nb;
         w = {6'($urandom_range(0, 7)), 10'($urandom)};
         sel = $urandom_range(0, 9);
         nb = (sel == 0) ? 15 : (sel == 1) ? 17 : 16;
         if (sel == 2) stray_edges($urandom_range(1, 6));
         send_frame(w, nb);
         check_all(nb != 16 ? "R3 random" : (w[15:10] >= NREG ? "R5 random" : "R8 random"));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule